// File: doc/BRIEF.md
# Supply Threshold Event Generator

This block watches the digital output of an analog supply comparator that reports whether the supply sits above or below a programmable trip point. It turns changes of that comparator signal into two kinds of notification. The first is a sticky interrupt-pending flag that software clears by writing one. The second is a single-cycle event strobe for wake-up or trigger fabric. The block also drives the 3-bit trip-point code back to the comparator and shows the synchronized comparator state as a status flag.

Software sets the trip point and the notification mode with one configuration write. That write loads the interrupt enable, the event enable and the two edge-direction enables together. Any enable that the write does not request ends up off, so an earlier setting never lingers. A separate monitor enable starts and stops detection. A standby input from the power controller forces the monitor off, whatever the monitor enable says. When the monitor becomes active, the first cycle is a settling window in which edges are ignored.

Top module: `supply_event_gen`

## Requirements
- R1: `level_out` is 0 after reset. It takes `cfg_level` on the clock edge where `cfg_we` is high, and holds its value on every other edge.
- R2: `status_out` equals the comparator input after a two-flop synchronizer, which adds two clock edges of latency. It reads 0 whenever the monitor is inactive. The monitor is active when `mon_en` is 1 and `standby` is 0.
- R3: When the rising-edge enable is set, a 0-to-1 change of the synchronized comparator is a qualifying edge.
- R4: When the falling-edge enable is set, a 1-to-0 change is a qualifying edge. Both directions may be enabled at once, and then each change qualifies. When a direction's enable is clear, changes in that direction are ignored.
- R5: A qualifying edge sets the interrupt flag only if the interrupt enable is set. It pulses the event output only if the event enable is set. The two enables are independent of each other.
- R6: A configuration write replaces all four enables (interrupt, event, rising, falling) with the written values. An enable written as 0 is off afterwards, even if it was on before.
- R7: While `standby` is 1, no edge qualifies and `status_out` is 0.
- R8: While `mon_en` is 0, no edge qualifies and `status_out` is 0.
- R9: A change of the synchronized comparator in the first cycle of an active period never qualifies. That first cycle follows reset, the rise of `mon_en`, or the exit from standby.
- R10: `irq_pend` is 0 after reset. Once set, it stays set until a cycle in which `irq_clr` is 1, and it clears on that edge. If a new edge sets it in the same cycle as the clear, it stays 1.
- R11: `evt_pulse` is high for exactly one cycle per qualifying edge. It rises on the third clock edge after the comparator input changes, and `irq_pend` sets on that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_level | input | 3 | Trip-point code to load |
| cfg_irq_en | input | 1 | Interrupt enable to load |
| cfg_evt_en | input | 1 | Event enable to load |
| cfg_rise_en | input | 1 | Rising-edge enable to load |
| cfg_fall_en | input | 1 | Falling-edge enable to load |
| mon_en | input | 1 | Monitor enable |
| standby | input | 1 | Standby state, forces the monitor off |
| irq_clr | input | 1 | Write-one-to-clear strobe for the pending flag |
| cmp_in | input | 1 | Asynchronous comparator output (1 = supply above trip point) |
| level_out | output | 3 | Trip-point code driven to the comparator |
| status_out | output | 1 | Synchronized comparator state, gated by monitor activity |
| irq_pend | output | 1 | Sticky interrupt-pending flag |
| evt_pulse | output | 1 | One-cycle event strobe |

## Verification
A stale synchronizer or edge-history flop shows up as a missing or extra event strobe. It appears on the third edge after a comparator change, and a wrong value shows there first. A settle counter that arms too early lets a strobe through right after `mon_en` rises or standby ends. A counter that never arms hides every later edge. A configuration register that merges new enables into old ones keeps producing interrupts or events after a write meant to turn them off. A sticky flag that misbehaves shows on `irq_pend` one edge after the clear or set cycle.

// File: rtl/supply_evt_pkg.sv
// Shared types for the supply threshold event generator.
// Assumes: nothing beyond IEEE 1800-2017 packed structs.
package supply_evt_pkg;

    // Notification mode loaded by one configuration write
    typedef struct packed {
        logic irq_en;
        logic evt_en;
        logic rise_en;
        logic fall_en;
    } trig_cfg_t;

endpackage

// File: rtl/supply_sync.sv
// Multi-flop synchronizer for the asynchronous comparator output.
// Assumes: STAGES >= 2; input toggles slower than the clock for a clean capture.
module supply_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous input through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/supply_edge_qual.sv
// Edge detector with per-direction enables and a settle window after activation.
// Assumes: lvl is already synchronous; SETTLE_CYC >= 1 cycles are ignored
// at the start of every active period.
module supply_edge_qual #(
    parameter int SETTLE_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic lvl,
    input  logic rise_en,
    input  logic fall_en,
    output logic hit
);

    localparam int                CNT_W   = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0]  CNT_MAX = CNT_W'(SETTLE_CYC);

    logic             prev_q;
    logic [CNT_W-1:0] settle_q;
    logic             armed;
    logic             rise_seen;
    logic             fall_seen;

    // Remember last synchronized level for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= lvl;
        end
    end

    // Count active cycles up to the settle limit; restart when inactive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            settle_q <= '0;
        end else if (!active) begin
            settle_q <= '0;
        end else if (settle_q != CNT_MAX) begin
            settle_q <= settle_q + 1'b1;
        end
    end

    // Qualify edges by direction enables and the armed state
    always_comb begin
        armed     = active && (settle_q == CNT_MAX);
        rise_seen = lvl && !prev_q;
        fall_seen = !lvl && prev_q;
        hit       = armed && ((rise_en && rise_seen) || (fall_en && fall_seen));
    end

endmodule

// File: rtl/supply_evt_out.sv
// Output stage: sticky write-one-to-clear interrupt flag and one-cycle event strobe.
// Assumes: hit is a single-cycle qualified edge indication.
module supply_evt_out (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic irq_en,
    input  logic evt_en,
    input  logic irq_clr,
    output logic irq_pend,
    output logic evt_pulse
);

    // Set wins over clear so no edge is lost
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_pend <= 1'b0;
        end else begin
            irq_pend <= (irq_pend && !irq_clr) || (hit && irq_en);
        end
    end

    // Register the event strobe for one cycle per edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_pulse <= 1'b0;
        end else begin
            evt_pulse <= hit && evt_en;
        end
    end

endmodule

// File: rtl/supply_event_gen.sv
// Top of the supply threshold event generator: holds the configuration,
// synchronizes the comparator, qualifies edges and drives notifications.
// Assumes: cmp_in is asynchronous; standby comes from the power controller.
module supply_event_gen
    import supply_evt_pkg::*;
#(
    parameter int LEVEL_W     = 3,
    parameter int SYNC_STAGES = 2,
    parameter int SETTLE_CYC  = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [LEVEL_W-1:0] cfg_level,
    input  logic               cfg_irq_en,
    input  logic               cfg_evt_en,
    input  logic               cfg_rise_en,
    input  logic               cfg_fall_en,
    input  logic               mon_en,
    input  logic               standby,
    input  logic               irq_clr,
    input  logic               cmp_in,
    output logic [LEVEL_W-1:0] level_out,
    output logic               status_out,
    output logic               irq_pend,
    output logic               evt_pulse
);

    trig_cfg_t          trig_q;
    logic [LEVEL_W-1:0] level_q;
    logic               active;
    logic               lvl_sync;
    logic               hit;

    // Load trip point and replace all enables on a configuration write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
            trig_q  <= '0;
        end else if (cfg_we) begin
            level_q <= cfg_level;
            trig_q  <= '{irq_en:  cfg_irq_en,
                         evt_en:  cfg_evt_en,
                         rise_en: cfg_rise_en,
                         fall_en: cfg_fall_en};
        end
    end

    // Monitor runs only when enabled and outside standby
    assign active     = mon_en && !standby;
    assign level_out  = level_q;
    assign status_out = active && lvl_sync;

    supply_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (cmp_in),
        .q_sync  (lvl_sync)
    );

    supply_edge_qual #(
        .SETTLE_CYC (SETTLE_CYC)
    ) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .lvl     (lvl_sync),
        .rise_en (trig_q.rise_en),
        .fall_en (trig_q.fall_en),
        .hit     (hit)
    );

    supply_evt_out u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .irq_en    (trig_q.irq_en),
        .evt_en    (trig_q.evt_en),
        .irq_clr   (irq_clr),
        .irq_pend  (irq_pend),
        .evt_pulse (evt_pulse)
    );

endmodule

// File: rtl/supply_evt_chk.sv
// Property checker for supply_event_gen, attached by bind.
// Assumes: clocked on the block clock with the same synchronous reset.
module supply_evt_chk #(
    parameter int LEVEL_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_we,
    input logic               mon_en,
    input logic               standby,
    input logic               irq_clr,
    input logic               irq_en,
    input logic               evt_en,
    input logic [LEVEL_W-1:0] level_out,
    input logic               status_out,
    input logic               irq_pend,
    input logic               evt_pulse
);

    logic act_w;
    assign act_w = mon_en && !standby;

    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(level_out)); // R1

    AST_STATUS_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> !status_out); // R7

    AST_STATUS_MON_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_en |-> !status_out); // R8

    AST_STANDBY_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> !evt_pulse); // R7

    AST_MON_OFF_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_en |=> !evt_pulse); // R8

    AST_SETTLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_w) |=> !evt_pulse); // R9

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pend) |-> $past(irq_en)); // R5

    AST_EVT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pulse |-> $past(evt_en)); // R5

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend && !irq_clr) |=> irq_pend); // R10

endmodule

bind supply_event_gen supply_evt_chk #(
    .LEVEL_W (LEVEL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .mon_en     (mon_en),
    .standby    (standby),
    .irq_clr    (irq_clr),
    .irq_en     (trig_q.irq_en),
    .evt_en     (trig_q.evt_en),
    .level_out  (level_out),
    .status_out (status_out),
    .irq_pend   (irq_pend),
    .evt_pulse  (evt_pulse)
);

// File: tb/sim_supply_event_gen.sv
module sim_supply_event_gen;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_level = '0;
    logic       cfg_irq_en = 1'b0;
    logic       cfg_evt_en = 1'b0;
    logic       cfg_rise_en = 1'b0;
    logic       cfg_fall_en = 1'b0;
    logic       mon_en = 1'b0;
    logic       standby = 1'b0;
    logic       irq_clr = 1'b0;
    logic       cmp_in = 1'b0;
    logic [2:0] level_out;
    logic       status_out;
    logic       irq_pend;
    logic       evt_pulse;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    supply_event_gen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_level(cfg_level),
        .cfg_irq_en(cfg_irq_en), .cfg_evt_en(cfg_evt_en),
        .cfg_rise_en(cfg_rise_en), .cfg_fall_en(cfg_fall_en),
        .mon_en(mon_en), .standby(standby), .irq_clr(irq_clr), .cmp_in(cmp_in),
        .level_out(level_out), .status_out(status_out),
        .irq_pend(irq_pend), .evt_pulse(evt_pulse)
    );

    // Reference model built from the requirements
    logic       m_s1, m_s2, m_prev, m_actp;
    logic [2:0] m_lvl;
    logic       m_irq_en, m_evt_en, m_rise, m_fall, m_pend, m_evt;

    function automatic logic exp_edge(logic act, logic actp, logic cur, logic prv,
                                      logic re, logic fe);
        return act && actp && ((re && cur && !prv) || (fe && !cur && prv));
    endfunction

    function automatic logic exp_status(logic mon, logic sb, logic s2);
        return mon && !sb && s2;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            {m_s1, m_s2, m_prev, m_actp} <= '0;
            m_lvl <= '0;
            {m_irq_en, m_evt_en, m_rise, m_fall, m_pend, m_evt} <= '0;
        end else begin
            m_s1   <= cmp_in;
            m_s2   <= m_s1;
            m_prev <= m_s2;
            m_actp <= mon_en && !standby;
            m_evt  <= exp_edge(mon_en && !standby, m_actp, m_s2, m_prev, m_rise, m_fall) && m_evt_en;
            m_pend <= (m_pend && !irq_clr) ||
                      (exp_edge(mon_en && !standby, m_actp, m_s2, m_prev, m_rise, m_fall) && m_irq_en);
            if (cfg_we) begin
                m_lvl    <= cfg_level;
                m_irq_en <= cfg_irq_en;
                m_evt_en <= cfg_evt_en;
                m_rise   <= cfg_rise_en;
                m_fall   <= cfg_fall_en;
            end
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Advance one clock and compare all outputs against the model
    task automatic tick();
        @(negedge clk);
        if (rst_n) begin
            chk("R1 level_out", 8'(level_out), 8'(m_lvl));
            chk("R2 status_out", 8'(status_out), 8'(exp_status(mon_en, standby, m_s2)));
            chk("R10 irq_pend", 8'(irq_pend), 8'(m_pend));
            chk("R11 evt_pulse", 8'(evt_pulse), 8'(m_evt));
        end
    endtask

    task automatic write_cfg(logic [2:0] lv, logic ie, logic ee, logic re, logic fe);
        cfg_level = lv; cfg_irq_en = ie; cfg_evt_en = ee;
        cfg_rise_en = re; cfg_fall_en = fe; cfg_we = 1'b1;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk("R1 reset level", 8'(level_out), 8'd0);
        chk("R10 reset pend", 8'(irq_pend), 8'd0);
        chk("R11 reset evt", 8'(evt_pulse), 8'd0);
        rst_n = 1'b1;
        mon_en = 1'b1;
        ticks(3);

        // R3: rising edge, both notifications
        write_cfg(3'd5, 1'b1, 1'b1, 1'b1, 1'b0);
        chk("R1 level loaded", 8'(level_out), 8'd5);
        cmp_in = 1'b1;
        ticks(2);
        chk("R2 status after sync", 8'(status_out), 8'd1);
        chk("R11 no early evt", 8'(evt_pulse), 8'd0);
        tick();
        chk("R3 rise evt", 8'(evt_pulse), 8'd1);
        chk("R3 rise irq", 8'(irq_pend), 8'd1);
        tick();
        chk("R11 evt one cycle", 8'(evt_pulse), 8'd0);
        chk("R10 pend sticky", 8'(irq_pend), 8'd1);
        irq_clr = 1'b1;
        tick();
        irq_clr = 1'b0;
        chk("R10 w1c clears", 8'(irq_pend), 8'd0);

        // R4: falling ignored with rise only, then both directions
        cmp_in = 1'b0;
        ticks(3);
        chk("R4 fall ignored", 8'(evt_pulse), 8'd0);
        write_cfg(3'd5, 1'b0, 1'b1, 1'b1, 1'b1);
        cmp_in = 1'b1;
        ticks(3);
        chk("R5 evt only", 8'(evt_pulse), 8'd1);
        chk("R5 no irq", 8'(irq_pend), 8'd0);
        cmp_in = 1'b0;
        ticks(3);
        chk("R4 fall evt", 8'(evt_pulse), 8'd1);

        // R6: write with no mode clears everything
        write_cfg(3'd2, 1'b0, 1'b0, 1'b0, 1'b0);
        cmp_in = 1'b1;
        ticks(3);
        chk("R6 cleared evt", 8'(evt_pulse), 8'd0);
        chk("R6 cleared irq", 8'(irq_pend), 8'd0);

        // R5: interrupt only
        write_cfg(3'd2, 1'b1, 1'b0, 1'b0, 1'b1);
        cmp_in = 1'b0;
        ticks(3);
        chk("R5 irq only set", 8'(irq_pend), 8'd1);
        chk("R5 irq only no evt", 8'(evt_pulse), 8'd0);
        irq_clr = 1'b1; tick(); irq_clr = 1'b0;

        // R7: standby blocks edges and status
        write_cfg(3'd0, 1'b1, 1'b1, 1'b1, 1'b1);
        standby = 1'b1;
        cmp_in = 1'b1;
        ticks(3);
        chk("R7 standby no evt", 8'(evt_pulse), 8'd0);
        chk("R7 standby status", 8'(status_out), 8'd0);
        tick();
        chk("R7 standby no irq", 8'(irq_pend), 8'd0);
        standby = 1'b0;
        ticks(3);

        // R8: monitor disabled
        mon_en = 1'b0;
        cmp_in = 1'b0;
        ticks(3);
        chk("R8 off no evt", 8'(evt_pulse), 8'd0);
        chk("R8 off status", 8'(status_out), 8'd0);
        chk("R8 off no irq", 8'(irq_pend), 8'd0);

        // R9: edge in first active cycle is suppressed
        cmp_in = 1'b1;
        ticks(2);
        mon_en = 1'b1;
        ticks(3);
        chk("R9 settle no evt", 8'(evt_pulse), 8'd0);
        chk("R9 settle no irq", 8'(irq_pend), 8'd0);
        chk("R9 status live", 8'(status_out), 8'd1);

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(3, 0) == 0) cmp_in = ~cmp_in;
            cfg_we = ($urandom_range(31, 0) == 0);
            cfg_level = 3'($urandom_range(7, 0));
            {cfg_irq_en, cfg_evt_en, cfg_rise_en, cfg_fall_en} = 4'($urandom_range(15, 0));
            irq_clr = ($urandom_range(7, 0) == 0);
            if ($urandom_range(63, 0) == 0) mon_en = ~mon_en;
            if ($urandom_range(63, 0) == 0) standby = ~standby;
            tick();
        end
        cfg_we = 1'b0;
        irq_clr = 1'b0;
        tick();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule